// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block switches bytes between time slots of a small set of serial time-division streams. Each input stream is shifted in, most significant bit first, and every complete channel byte is stored in a two-half data memory. One half collects the current frame while the other holds the frame before it. The halves swap on every frame start. For each output channel, a per-channel connection entry chooses what goes out. It can carry a switched byte from any input stream and channel, or a fixed message byte. The entry can also float the output for that channel, and it chooses between a fixed one-frame delay and the lowest delay available.

A one-cycle `frame_start` pulse marks where a frame begins. Each bit lasts two clocks. A small configuration port sets the stream rate, which decides how many channels a frame holds. The same port writes connection entries one at a time, or fills every entry of one output stream with a single write. A global `drive_en` input can float all outputs at once.

Top module: `tsi_switch`

## Requirements
- R1: The rate code is written with `cfg_sel`=1 in `cfg_wdata[1:0]`. Code n gives 4<<n channels per frame on every stream (4, 8 or 16), and code 3 behaves as code 2.
- R2: A frame begins at the rising edge where `frame_start` is high; the cycle after that edge is cycle 0. Each channel takes 16 clocks and each bit takes 2 clocks, most significant bit first. Output bit b of channel c is driven in cycles 16c+2(7-b) and 16c+2(7-b)+1. Input bits use the same positions and are sampled at the edge that ends the first of the two cycles.
- R3: A switched entry has bit 9 = 0. Output channel c of stream o then carries the byte received on input stream `payload[4]`, channel `payload[3:0]`, for any pair of stream and channel.
- R4: With entry bit 8 = 1 (constant delay), the switched byte comes from the previous frame.
- R5: With entry bit 8 = 0 (variable delay), the byte comes from the current frame when the source channel is lower than c, and from the previous frame otherwise.
- R6: With entry bit 9 = 1 (message), the channel transmits `payload[7:0]` (entry bits 7..0).
- R7: With entry bit 10 = 1, `ser_oe` for that stream is low for the whole channel.
- R8: While `drive_en` is low, every `ser_oe` is low. Whenever `ser_oe` is low, `ser_out` is 0.
- R9: A write with `cfg_we`=1 and `cfg_sel`=0 stores `cfg_wdata` into the entry of stream `cfg_addr[4]`, channel `cfg_addr[3:0]`. With `cfg_blk`=1, the same write fills every channel of that stream in one cycle and ignores the channel field.
- R10: After reset, `ser_oe` is low, the rate code is 0 and every entry is zero (switched, variable delay, stream 0 channel 0).
- R11: Outside a frame, `ser_oe` is low. This covers the time before the first frame start, and the time from the channel count onward until the next frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, two periods per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame start marker |
| drive_en | input | 1 | Global output drive enable |
| ser_in | input | 2 | Serial input streams |
| ser_out | output | 2 | Serial output streams |
| ser_oe | output | 2 | Per-stream output drive enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 1 selects the rate register, 0 the connection entries |
| cfg_blk | input | 1 | Fill every channel of the addressed stream |
| cfg_addr | input | 5 | Stream (bit 4) and channel (bits 3..0) |
| cfg_wdata | input | 11 | Entry {float, message, constant delay, payload[7:0]} or rate code |

## Verification
The bench uses the package defaults: two streams and 4 base channels, so the longest frame is 16 channels of 256 clocks. That size lets every output bit of every channel be compared in every checked frame, at all four rate codes. The connection maps are built by formula. They mix cross-stream and same-stream sources, source channels both below and above the output channel, message slots and floated slots, so both delay modes meet both half-selection cases. The bench also covers a frame run on reset-default entries, a frame with drive disabled, and a block fill that must leave the other stream's map in place.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int NS       = 2;
    localparam int BASE_CH  = 4;
    localparam int MAX_RATE = 2;
    localparam int MAXCH    = BASE_CH << MAX_RATE;
    localparam int SW       = (NS > 1) ? $clog2(NS) : 1;
    localparam int CW       = $clog2(MAXCH);
    localparam int BITCLK   = 2;
    localparam int SLOTCLK  = 8 * BITCLK;
    localparam int SLOTW    = $clog2(SLOTCLK);
    localparam int CNTW     = CW + SLOTW + 1;
    localparam int AW       = SW + CW;

    typedef logic [SW-1:0] st_t;
    typedef logic [CW-1:0] ch_t;

    typedef struct packed {
        logic       hiz;
        logic       msg;
        logic       cdly;
        logic [7:0] payload;
    } conn_t;

    localparam int CONN_W = $bits(conn_t);

    function automatic logic [CW:0] chan_count(input logic [1:0] rate);
        return (CW+1)'(BASE_CH) << rate;
    endfunction

    function automatic ch_t src_ch(input conn_t e);
        return e.payload[CW-1:0];
    endfunction

    function automatic st_t src_st(input conn_t e);
        return e.payload[AW-1:CW];
    endfunction
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_start,
    input  logic [1:0]   rate,
    output logic         half,
    output logic [CW:0]  chan_full,
    output logic         in_frame,
    output logic [2:0]   bit_idx,
    output logic         mid,
    output logic         slot_end
);
    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '1;
            half <= 1'b0;
        end else if (frame_start) begin
            cnt  <= '0;
            half <= ~half;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign chan_full = cnt[CNTW-1:SLOTW];
    assign in_frame  = chan_full < chan_count(rate);
    assign bit_idx   = cnt[SLOTW-1:1];
    assign mid       = ~cnt[0];
    assign slot_end  = &cnt[SLOTW-1:0];

    a_r2_frame_restart: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (chan_full == '0 && bit_idx == 3'd0 && mid));
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_in,
    input  logic       sample,
    input  logic       last_bit,
    output logic       wr_en,
    output logic [7:0] wr_byte
);
    logic [6:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            sh <= '0;
        else if (sample)
            sh <= {sh[5:0], ser_in};
    end

    assign wr_en   = sample & last_bit;
    assign wr_byte = {sh, ser_in};

    a_r2_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic              cfg_blk,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CONN_W-1:0] cfg_wdata,
    input  ch_t               rd_ch,
    output conn_t             ent [NS],
    output logic [1:0]        rate_q
);
    conn_t mem [NS][MAXCH];
    st_t   a_st;
    ch_t   a_ch;

    assign a_st = cfg_addr[AW-1:CW];
    assign a_ch = cfg_addr[CW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            for (int s = 0; s < NS; s++)
                for (int c = 0; c < MAXCH; c++)
                    mem[s][c] <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) begin
                rate_q <= (cfg_wdata[1:0] > 2'(MAX_RATE)) ? 2'(MAX_RATE) : cfg_wdata[1:0];
            end else begin
                for (int c = 0; c < MAXCH; c++)
                    if (cfg_blk || a_ch == CW'(c))
                        mem[a_st][c] <= conn_t'(cfg_wdata);
            end
        end
    end

    always_comb begin
        for (int s = 0; s < NS; s++)
            ent[s] = mem[s][rd_ch];
    end

    a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rate_q == 2'd0 && ent[0] == '0));

    for (genvar g = 0; g < NS; g++) begin : g_blk_chk
        a_r9_block_fill: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !cfg_sel && cfg_blk && a_st == st_t'(g)) |=>
            (mem[g][0] == $past(cfg_wdata) && mem[g][MAXCH-1] == $past(cfg_wdata)));
    end
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       load_valid,
    input  ch_t        nxt_ch,
    input  conn_t      ent,
    input  logic       prev_half,
    input  logic       cur_half,
    input  logic [2:0] bit_idx,
    input  logic       drive_en,
    input  logic [7:0] rd_byte,
    output logic       rd_half,
    output st_t        rd_st,
    output ch_t        rd_ch,
    output logic       ser_out,
    output logic       ser_oe
);
    logic [7:0] byte_q;
    logic       oe_q;
    logic       use_cur;

    assign use_cur = !ent.cdly && (src_ch(ent) < nxt_ch);
    assign rd_half = use_cur ? cur_half : prev_half;
    assign rd_st   = src_st(ent);
    assign rd_ch   = src_ch(ent);

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_q <= '0;
            oe_q   <= 1'b0;
        end else if (load) begin
            oe_q   <= load_valid && !ent.hiz;
            byte_q <= ent.msg ? ent.payload : rd_byte;
        end
    end

    assign ser_oe  = oe_q & drive_en;
    assign ser_out = ser_oe & byte_q[3'd7 - bit_idx];

    a_r7_hiz_channel: assert property (@(posedge clk) disable iff (rst)
        (load && ent.hiz) |=> !ser_oe);

    a_r6_message_msb: assert property (@(posedge clk) disable iff (rst)
        (load && load_valid && ent.msg && !ent.hiz) |=>
        (!ser_oe || ser_out == $past(ent.payload[7])));
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              drive_en,
    input  logic [NS-1:0]     ser_in,
    output logic [NS-1:0]     ser_out,
    output logic [NS-1:0]     ser_oe,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic              cfg_blk,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [CONN_W-1:0] cfg_wdata
);
    logic        half, in_frame, mid, slot_end;
    logic [CW:0] chan_full, nxt, nch;
    logic [2:0]  bit_idx;
    logic [1:0]  rate_q;
    logic        load, load_valid, prev_half;
    conn_t       ent [NS];

    logic [7:0]  dmem [2][NS][MAXCH];
    logic        rx_we   [NS];
    logic [7:0]  rx_byte [NS];
    logic        rd_half [NS];
    st_t         rd_st   [NS];
    ch_t         rd_ch   [NS];
    logic [7:0]  rd_byte [NS];

    tsi_timing u_timing (
        .clk(clk), .rst(rst), .frame_start(frame_start), .rate(rate_q),
        .half(half), .chan_full(chan_full), .in_frame(in_frame),
        .bit_idx(bit_idx), .mid(mid), .slot_end(slot_end)
    );

    assign nch        = chan_count(rate_q);
    assign load       = frame_start | (in_frame & slot_end);
    assign nxt        = frame_start ? '0 : chan_full + 1'b1;
    assign load_valid = nxt < nch;
    assign prev_half  = frame_start ? half : ~half;

    tsi_cmem u_cmem (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_blk(cfg_blk),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_ch(nxt[CW-1:0]),
        .ent(ent), .rate_q(rate_q)
    );

    for (genvar g = 0; g < NS; g++) begin : g_stream
        tsi_rx u_rx (
            .clk(clk), .rst(rst), .ser_in(ser_in[g]),
            .sample(in_frame & mid), .last_bit(bit_idx == 3'd7),
            .wr_en(rx_we[g]), .wr_byte(rx_byte[g])
        );

        assign rd_byte[g] = dmem[rd_half[g]][rd_st[g]][rd_ch[g]];

        tsi_tx u_tx (
            .clk(clk), .rst(rst), .load(load), .load_valid(load_valid),
            .nxt_ch(nxt[CW-1:0]), .ent(ent[g]), .prev_half(prev_half),
            .cur_half(half), .bit_idx(bit_idx), .drive_en(drive_en),
            .rd_byte(rd_byte[g]), .rd_half(rd_half[g]), .rd_st(rd_st[g]),
            .rd_ch(rd_ch[g]), .ser_out(ser_out[g]), .ser_oe(ser_oe[g])
        );
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++)
            if (rx_we[s])
                dmem[half][s][chan_full[CW-1:0]] <= rx_byte[s];
    end

    a_r8_global_float: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (ser_oe == '0 && ser_out == '0));

    a_r11_idle_float: assert property (@(posedge clk) disable iff (rst)
        !in_frame |-> (ser_oe == '0));
endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    import tsi_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst, frame_start, drive_en, cfg_we, cfg_sel, cfg_blk;
    logic [NS-1:0]     ser_in, ser_out, ser_oe;
    logic [AW-1:0]     cfg_addr;
    logic [CONN_W-1:0] cfg_wdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [CONN_W-1:0] m_ent [NS][MAXCH];
    int m_rate = 0;

    tsi_switch u_tsi_switch (.*);

    function automatic logic [7:0] in_byte(int seed, int f, int st, int ch);
        return 8'((seed * 7 + f * 53 + st * 29 + ch * 11) ^ 'h5C);
    endfunction

    function automatic logic [CONN_W-1:0] make_ent(int o, int c, int nch, int rate);
        logic [7:0] pl;
        int st = (o + c + rate) % NS;
        int s  = (c * 5 + 3 + o) % nch;
        bit msg = (c % 5 == 4);
        pl = msg ? 8'(160 + c + o * 16) : 8'(st * MAXCH + s);
        return {(c % 7 == 6), msg, (c % 3 == 0), pl};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(bit sel, bit blk, int addr, logic [CONN_W-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_blk = blk;
        cfg_addr = AW'(addr); cfg_wdata = d;
        if (sel) m_rate = (d[1:0] > 2'(MAX_RATE)) ? MAX_RATE : int'(d[1:0]);
        else
            for (int ch = 0; ch < MAXCH; ch++)
                if (blk || ch == addr % MAXCH) m_ent[addr / MAXCH][ch] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run(int seed, int nfr, string ftag);
        int nch = BASE_CH << m_rate;
        int fl  = nch * SLOTCLK;
        @(negedge clk);
        frame_start = 1'b1;
        ser_in = '0;
        for (int f = 0; f < nfr; f++) begin
            for (int k = 0; k < fl; k++) begin
                int c = k / SLOTCLK;
                int b = 7 - (k % SLOTCLK) / 2;
                @(negedge clk);
                frame_start = (k == fl - 1) && (f < nfr - 1);
                for (int st = 0; st < NS; st++) begin
                    logic [7:0] ib = in_byte(seed, f, st, c);
                    ser_in[st] = ib[b];
                end
                if (f > 0) begin
                    for (int o = 0; o < NS; o++) begin
                        logic [CONN_W-1:0] e = m_ent[o][c];
                        logic [7:0] eb;
                        int s   = int'(e[CW-1:0]);
                        int sst = int'(e[AW-1:CW]);
                        bit eoe = drive_en && !e[10];
                        bit ebit;
                        string tag;
                        if (e[9]) eb = e[7:0];
                        else eb = in_byte(seed, (!e[8] && s < c) ? f : f - 1, sst, s);
                        ebit = eoe ? eb[b] : 1'b0;
                        if (ftag != "") tag = ftag;
                        else if (e[10]) tag = "R7";
                        else if (e[9]) tag = "R6";
                        else if (e[8]) tag = "R4";
                        else tag = "R5";
                        chk(ser_oe[o] == eoe, tag, int'(ser_oe[o]), int'(eoe));
                        chk(ser_out[o] == ebit, tag, int'(ser_out[o]), int'(ebit));
                        if (ftag == "") begin
                            if (k % 2 == 0)   // R2: first clock of each bit
                                chk(ser_out[o] == ebit, "R2", int'(ser_out[o]), int'(ebit));
                            if (c == nch - 1 && k % SLOTCLK == 0)   // R1: last channel present
                                chk(ser_oe[o] == eoe, "R1", int'(ser_oe[o]), int'(eoe));
                            if (!e[9] && sst != o && eoe && k % SLOTCLK == 0)
                                chk(ser_out[o] == ebit, "R3", int'(ser_out[o]), int'(ebit));
                        end
                    end
                end
            end
        end
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            frame_start = 1'b0;
            chk(ser_oe == '0, "R11", int'(ser_oe), 0);
            chk(ser_out == '0, "R11", int'(ser_out), 0);
        end
    endtask

    initial begin
        rst = 1'b1; frame_start = 1'b0; drive_en = 1'b1; ser_in = '0;
        cfg_we = 1'b0; cfg_sel = 1'b0; cfg_blk = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int s = 0; s < NS; s++)
            for (int c = 0; c < MAXCH; c++) m_ent[s][c] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_oe == '0, "R10", int'(ser_oe), 0);
        chk(ser_out == '0, "R10", int'(ser_out), 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(ser_oe == '0, "R11", int'(ser_oe), 0);
        end
        // R10: default entries and rate 0 without any configuration
        run(1, 2, "R10");
        // R1, R3, R4, R5, R6, R7 over every rate code, code 3 clamps to 16 channels
        for (int r = 0; r < 4; r++) begin
            int nch = BASE_CH << ((r > MAX_RATE) ? MAX_RATE : r);
            cfg(1'b1, 1'b0, 0, CONN_W'(r));
            for (int o = 0; o < NS; o++)
                for (int c = 0; c < nch; c++)
                    cfg(1'b0, 1'b0, o * MAXCH + c, make_ent(o, c, nch, r));
            run(r + 2, 3, "");
        end
        // R8: global drive disable
        drive_en = 1'b0;
        run(9, 2, "R8");
        drive_en = 1'b1;
        // R9: block fill of stream 1 with a message byte, stream 0 map kept
        cfg(1'b0, 1'b1, 1 * MAXCH + 3, {3'b010, 8'h5A});
        run(10, 2, "R9");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the run completed");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule